// File: doc/BRIEF.md
# Half-to-Single Precision Widener

This block takes an IEEE-754 binary16 operand and produces the binary32 value that equals it. Every half value has an exact single-precision counterpart, so the block never rounds. Each input is first sorted into one of five classes: zero, subnormal, normal, infinity or NaN. Each class has its own way of building the single-precision fields. A subnormal half becomes a normal single. A one-pass leading-one search finds the shift that puts the most significant set bit into the hidden-bit position, and the exponent is lowered by the same amount. NaNs leave the block quiet, and their payload and sign are kept.

Operands enter and results leave on valid/ready streams. The input side accepts an operand on a cycle where `in_valid` and `in_ready` are both high. The output side hands over a result on a cycle where `out_valid` and `out_ready` are both high. With the default registered option, a result appears one cycle after it is accepted. While a result waits with `out_ready` low, it stays unchanged and `in_ready` drops, so back-pressure passes straight through to the producer. When the registered option is turned off, the datapath is purely combinational and the handshake signals pass straight through the block.

Top module: `hw_half_widen`

## Requirements
- R1: A normal half (exponent field 1 to 30 in bits 14:10) gives a single with exponent field equal to the half exponent plus 112, mantissa bits 22:13 equal to half bits 9:0, mantissa bits 12:0 equal to zero, and the same sign in bit 31.
- R2: A subnormal half (exponent field 0, nonzero mantissa) is normalized. Let s (1 to 10) be the left shift that moves its leading one to bit 10. The output exponent field is 113 minus s. The output mantissa is the shifted mantissa with that leading one removed, placed in bits 22:13, with zeros below.
- R3: A half with zero exponent and zero mantissa gives a zero single with the same sign (0x00000000 or 0x80000000).
- R4: A half with exponent field 31 and zero mantissa gives an infinity with the same sign (0x7F800000 or 0xFF800000).
- R5: A half with exponent field 31 and nonzero mantissa gives a NaN. Its exponent field is all ones and bit 22 is forced to 1. Half mantissa bits 8:0 land in bits 21:13, bits 12:0 are zero, and the sign is kept.
- R6: In registered mode, an operand accepted on one clock edge shows up with `out_valid` high after the next edge. `out_valid` falls once the result has been taken and no new operand was accepted.
- R7: While `out_valid` is high and `out_ready` is low, `out_single` and `out_valid` hold, `in_ready` is low, and no new operand is accepted. `in_ready` equals `!out_valid || out_ready`.
- R8: While `rst_n` is low and just after reset, `out_valid` is 0 and `in_ready` is 1.
- R9: For all 65536 inputs, narrowing the result back to binary16 with round-to-nearest-even gives the original half. For NaN inputs the result is the original half with bit 9 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can accept an operand |
| in_half | input | 16 | binary16 operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_single | output | 32 | binary32 result |

## Verification
The corner cases the bench goes after are the subnormal edges: 0x0001 needs the full ten-place shift, and 0x03FF and 0x0200 need a single place. An off-by-one in the priority encoder or in the 113 offset would give a result twice or half the true value, or would leave the leading one in the mantissa. Signaling NaNs with small payloads such as 0x7C01 are also checked. A design that did not force the quiet bit would turn them into infinity or leave a signaling NaN. Signed zeros and infinities catch any loss of the sign. A stall with a competing operand shows whether a design drops or overwrites a held result. A sweep of every code, round-tripped through an independent narrowing model, catches any remaining mistake in the field arithmetic.

// File: rtl/hw_fp_pkg.sv
package hw_fp_pkg;
  typedef enum logic [2:0] {
    K_ZERO,
    K_SUB,
    K_NORM,
    K_INF,
    K_NAN
  } fp_kind_e;
endpackage

// File: rtl/hw_kind_decode.sv
module hw_kind_decode
  import hw_fp_pkg::*;
#(
  parameter int HEXP = 5,
  parameter int HMAN = 10,
  localparam int HW  = 1 + HEXP + HMAN
) (
  input  logic [HW-1:0]   half_i,
  output logic            sign_o,
  output logic [HEXP-1:0] exp_o,
  output logic [HMAN-1:0] man_o,
  output fp_kind_e        kind_o
);
  assign sign_o = half_i[HW-1];
  assign exp_o  = half_i[HW-2 -: HEXP];
  assign man_o  = half_i[HMAN-1:0];

  always_comb begin
    if (exp_o == '1)      kind_o = (man_o != '0) ? K_NAN : K_INF;
    else if (exp_o == '0) kind_o = (man_o != '0) ? K_SUB : K_ZERO;
    else                  kind_o = K_NORM;
  end
endmodule

// File: rtl/hw_lead_norm.sv
module hw_lead_norm #(
  parameter int HMAN = 10,
  localparam int SHW = $clog2(HMAN + 1)
) (
  input  logic [HMAN-1:0] man_i,
  output logic [SHW-1:0]  shift_o,
  output logic [HMAN-1:0] frac_o
);
  // Priority encoder: the highest set bit wins because it is visited last.
  always_comb begin
    shift_o = '0;
    for (int b = 0; b < HMAN; b++) begin
      if (man_i[b]) shift_o = SHW'(HMAN - b);
    end
  end

  // Shifting inside an HMAN-wide result pushes the leading one out of range.
  assign frac_o = man_i << shift_o;
endmodule

// File: rtl/hw_field_pack.sv
module hw_field_pack
  import hw_fp_pkg::*;
#(
  parameter int HEXP = 5,
  parameter int HMAN = 10,
  parameter int SEXP = 8,
  parameter int SMAN = 23,
  localparam int SHW = $clog2(HMAN + 1),
  localparam int SW  = 1 + SEXP + SMAN,
  localparam int MSH = SMAN - HMAN,
  localparam int BIAS_H = (1 << (HEXP - 1)) - 1,
  localparam int BIAS_S = (1 << (SEXP - 1)) - 1,
  localparam int DELTA  = BIAS_S - BIAS_H
) (
  input  fp_kind_e        kind_i,
  input  logic            sign_i,
  input  logic [HEXP-1:0] exp_i,
  input  logic [HMAN-1:0] man_i,
  input  logic [SHW-1:0]  shift_i,
  input  logic [HMAN-1:0] frac_i,
  output logic [SW-1:0]   single_o
);
  localparam logic [SEXP-1:0] DELTA_S = SEXP'(DELTA);
  localparam logic [SEXP-1:0] SUBTOP  = SEXP'(DELTA + 1);

  logic [SEXP-1:0] exp_norm, exp_sub;
  assign exp_norm = DELTA_S + SEXP'(exp_i);
  assign exp_sub  = SUBTOP - SEXP'(shift_i);

  always_comb begin
    unique case (kind_i)
      K_ZERO:  single_o = {sign_i, {(SW-1){1'b0}}};
      K_INF:   single_o = {sign_i, {SEXP{1'b1}}, {SMAN{1'b0}}};
      K_NAN:   single_o = {sign_i, {SEXP{1'b1}}, 1'b1, man_i[HMAN-2:0], {MSH{1'b0}}};
      K_SUB:   single_o = {sign_i, exp_sub, frac_i, {MSH{1'b0}}};
      default: single_o = {sign_i, exp_norm, man_i, {MSH{1'b0}}};
    endcase
  end
endmodule

// File: rtl/hw_half_widen.sv
module hw_half_widen
  import hw_fp_pkg::*;
#(
  parameter int HEXP    = 5,
  parameter int HMAN    = 10,
  parameter int SEXP    = 8,
  parameter int SMAN    = 23,
  parameter bit REG_OUT = 1'b1,
  localparam int HW  = 1 + HEXP + HMAN,
  localparam int SW  = 1 + SEXP + SMAN,
  localparam int SHW = $clog2(HMAN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [HW-1:0] in_half,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_single
);
  logic            sgn;
  logic [HEXP-1:0] hexp;
  logic [HMAN-1:0] hman, nfrac;
  logic [SHW-1:0]  nshift;
  fp_kind_e        kind;
  logic [SW-1:0]   conv;

  hw_kind_decode #(.HEXP(HEXP), .HMAN(HMAN)) u_dec (
    .half_i(in_half), .sign_o(sgn), .exp_o(hexp), .man_o(hman), .kind_o(kind)
  );

  hw_lead_norm #(.HMAN(HMAN)) u_norm (
    .man_i(hman), .shift_o(nshift), .frac_o(nfrac)
  );

  hw_field_pack #(.HEXP(HEXP), .HMAN(HMAN), .SEXP(SEXP), .SMAN(SMAN)) u_pack (
    .kind_i(kind), .sign_i(sgn), .exp_i(hexp), .man_i(hman),
    .shift_i(nshift), .frac_i(nfrac), .single_o(conv)
  );

  // R2: a subnormal mantissa always yields a shift inside 1..HMAN
  p_shift_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SUB) |-> (nshift >= SHW'(1) && nshift <= SHW'(HMAN)));

  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q;
      logic [SW-1:0] dat_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else begin
          if (in_ready) vld_q <= in_valid;
          if (in_valid && in_ready) dat_q <= conv;
        end
      end

      assign out_valid  = vld_q;
      assign out_single = dat_q;

      p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_single)));
      p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
      p_nan_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_single[SW-2 -: SEXP] == '1 && out_single[SMAN-1:0] != '0)
          |-> out_single[SMAN-1]);
    end else begin : g_comb
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_single = conv;
    end
  endgenerate
endmodule

// File: tb/test_hw_half_widen.sv
module test_hw_half_widen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_single;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hw_half_widen i_hw_half_widen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_half(in_half), .out_valid(out_valid), .out_ready(out_ready),
    .out_single(out_single)
  );

  // {half, expected single}
  localparam logic [47:0] VEC [16] = '{
    {16'h0000, 32'h00000000}, {16'h8000, 32'h80000000},
    {16'h3C00, 32'h3F800000}, {16'hC000, 32'hC0000000},
    {16'h7BFF, 32'h477FE000}, {16'h0001, 32'h33800000},
    {16'h03FF, 32'h387FC000}, {16'h0200, 32'h38000000},
    {16'h0400, 32'h38800000}, {16'h7C00, 32'h7F800000},
    {16'hFC00, 32'hFF800000}, {16'h7E00, 32'h7FC00000},
    {16'h7C01, 32'h7FC02000}, {16'hFD55, 32'hFFEAA000},
    {16'h8001, 32'hB3800000}, {16'h3555, 32'h3EAAA000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] h);
    if (h[14:10] == 5'h1F) return (h[9:0] != 0) ? "R5" : "R4";
    if (h[14:10] == 5'h00) return (h[9:0] != 0) ? "R2" : "R3";
    return "R1";
  endfunction

  // Independent binary32 -> binary16 model, round to nearest even.
  function automatic logic [15:0] narrow_rne(input logic [31:0] f);
    logic        s;
    logic [7:0]  e;
    logic [31:0] full, rem, hlf;
    logic [14:0] base;
    int ue, sh;
    logic up;
    s = f[31]; e = f[30:23];
    if (e == 8'hFF)
      return (f[22:0] != 0) ? {s, 5'h1F, 1'b1, f[21:13]} : {s, 5'h1F, 10'h000};
    if (e == 0 && f[22:0] == 0) return {s, 15'd0};
    ue = int'(e) - 127;
    if (ue > 15) return {s, 5'h1F, 10'h000};
    if (ue < -25) return {s, 15'd0};
    full = {8'd0, (e != 0), f[22:0]};
    sh = (ue >= -14) ? 13 : 13 + (-14 - ue);
    if (ue >= -14) base = {5'(ue + 15), f[22:13]};
    else           base = {5'd0, 10'(full >> sh)};
    hlf = 32'd1 << (sh - 1);
    rem = full & ((32'd1 << sh) - 1);
    up = (rem > hlf) || (rem == hlf && base[0]);
    return {s, base + 15'(up)};
  endfunction

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] prev, want;
    repeat (3) @(negedge clk);
    chk("R8 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R8 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 out_valid after reset", {31'd0, out_valid}, 32'd0);

    // Table walk: fixed vectors, one at a time, with latency check (R6)
    foreach (VEC[k]) begin
      in_half = VEC[k][47:32]; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 valid after one cycle", {31'd0, out_valid}, 32'd1);
      chk(tag_of(VEC[k][47:32]), out_single, VEC[k][31:0]);
    end
    @(negedge clk);
    chk("R6 valid drops when drained", {31'd0, out_valid}, 32'd0);

    // Back-pressure (R7)
    out_ready = 1'b0;
    in_half = 16'h3C00; in_valid = 1'b1;
    @(negedge clk);
    in_half = 16'h4000;
    chk("R7 held result", out_single, 32'h3F800000);
    chk("R7 in_ready low on stall", {31'd0, in_ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R7 result stable under stall", out_single, 32'h3F800000);
    chk("R7 valid stable under stall", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 next operand after release", out_single, 32'h40000000);
    @(negedge clk);
    chk("R7 drained", {31'd0, out_valid}, 32'd0);

    // Full sweep with round trip (R9)
    prev = '0;
    for (int i = 0; i <= 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        want = prev;
        if (prev[14:10] == 5'h1F && prev[9:0] != 0) want[9] = 1'b1;
        n_chk++;
        if (!out_valid || narrow_rne(out_single) !== want) begin
          n_bad++;
          $display("FAIL R9 in=%h actual=%h(v%0b) expected=%h", prev,
                   narrow_rne(out_single), out_valid, want);
        end
      end
      if (i < 65536) begin
        in_half = 16'(i); in_valid = 1'b1; prev = 16'(i);
      end else begin
        in_valid = 1'b0;
      end
    end

    // Reset in the middle of traffic (R8)
    in_half = 16'h3C00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 reset clears valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule